// File: doc/BRIEF.md
# Stipple and Block-Copy Engine

This block is a small 2-D drawing accelerator that owns an on-chip frame memory of 8-bit pixels and, when the deep-colour option is built in, a companion plane of 24-bit pixels. Software drives it with pairs of 32-bit writes on a simple valid/ready register bus. The first write of a pair loads a colour word. The second write, the execute write, carries the whole command in its address and data. The address gives the destination pixel and the engine selection. The data is either a 32-bit stipple mask or a block-transfer descriptor.

A stipple expands the mask into up to 32 coloured pixels. A block transfer either copies a run of 1 to 32 pixels from a source index or fills the run with the colour. The engine writes at most one pixel per clock. It drops `wr_ready` while it works, so later writes on the bus wait. A side view port reads any pixel of both planes combinationally. The bus read data of the engine's window is always zero.

The sequencer has four states. IDLE waits for a command. STIPPLE, FILL and COPY each run one pixel per cycle. The transitions are: IDLE to STIPPLE on an accepted execute write with engine bit 0. IDLE to FILL on an accepted execute write with engine bit 1 and an all-ones source field. IDLE to COPY on any other accepted execute write with engine bit 1. Each of STIPPLE, FILL and COPY returns to IDLE in the cycle its last pixel is handled.

Top module: `stipple_blit_engine`

## Requirements
- R1: A write accepted with `wr_addr[2]`=0 stores `wr_data` as the colour word and changes no pixel. `busy` stays low after it.
- R2: After reset `wr_ready`=1 and `busy`=0, and every pixel of both planes reads zero.
- R3: A write accepted with `wr_addr[2]`=1 executes. The destination index is `wr_addr[22:3]` taken modulo NPIX, where NPIX is a power of two. `wr_addr[23]`=0 selects stipple and `wr_addr[23]`=1 selects block transfer.
- R4: A stipple scans `wr_data` from bit 31 down to bit 0. A set bit at scan position i, where bit 31 is position 0, writes the colour's low byte to pixel dst+i. A clear bit leaves that pixel unchanged. `busy` is high for exactly 32 cycles, starting the cycle after acceptance.
- R5: In a block transfer, `wr_data[28:24]`+1 is the run length L (1 to 32). `busy` is high for exactly L cycles.
- R6: If `wr_data[23:0]` equals 24'hFFFFFF, the run dst..dst+L-1 is filled with the colour's low byte.
- R7: Otherwise pixel src+i is copied to dst+i, with src = `wr_data[23:0]` modulo NPIX. Pixels are handled in ascending i, and each source pixel is read before that step's write, so overlapping runs propagate.
- R8: With the deep-colour plane built, stipple and fill also write the colour's bits 23:0 to the 24-bit plane, and copy moves 24-bit pixels in step with the 8-bit ones.
- R9: `rd_data` is zero at all times.
- R10: `wr_ready` is low whenever `busy` is high. A write presented during that time is held and takes effect only after the running command ends.
- R11: Pixel indices wrap modulo NPIX for both the destination and the source as a run advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Bus write request |
| wr_ready | output | 1 | Engine can accept a write |
| wr_addr | input | 22 | Byte address bits 23:2 of the write |
| wr_data | input | 32 | Write data: colour, mask or descriptor |
| rd_data | output | 32 | Bus read data of the window (always zero) |
| busy | output | 1 | A command is running |
| view_idx | input | PAW | Pixel index for the view port |
| view_pix8 | output | 8 | 8-bit pixel at `view_idx` |
| view_pix24 | output | 24 | 24-bit pixel at `view_idx` (zero when that plane is absent) |

## Verification
If the run counter or stored length is wrong, `busy` stays high a cycle too long or falls too early. The bench compares `busy` and `wr_ready` against its model on every clock, so this shows at once. A mask register shifting the wrong way or an index that fails to step shows up as misplaced pixels. These are caught when both planes are scanned through the view port once the command ends. A stale colour word or a wrong copy order appears only in the pixel values. Back-to-back commands with overlapping runs are aimed at exposing it on the first scan after the pair.

// File: rtl/sbe_pkg.sv
package sbe_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_STIPPLE = 2'd1,
        ST_FILL    = 2'd2,
        ST_COPY    = 2'd3
    } eng_state_e;

    localparam int MASK_W   = 32;
    localparam int DST_W    = 20;
    localparam int SRC_W    = 24;
    localparam int LEN_W    = 5;
    localparam logic [SRC_W-1:0] FILL_CODE = '1;
endpackage

// File: rtl/sbe_plane.sv
module sbe_plane #(
    parameter int W    = 8,
    parameter int NPIX = 512,
    localparam int PAW = $clog2(NPIX)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           we,
    input  logic [PAW-1:0] waddr,
    input  logic [W-1:0]   wdata,
    input  logic [PAW-1:0] raddr,
    output logic [W-1:0]   rdata,
    input  logic [PAW-1:0] vaddr,
    output logic [W-1:0]   vdata
);
    logic [W-1:0] mem [NPIX];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NPIX; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
    assign vdata = mem[vaddr];
endmodule

// File: rtl/sbe_seq.sv
module sbe_seq
    import sbe_pkg::*;
#(
    parameter int NPIX = 512,
    localparam int PAW = $clog2(NPIX)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  eng_state_e        start_op,
    input  logic [DST_W-1:0]  start_dst,
    input  logic [SRC_W-1:0]  start_src,
    input  logic [LEN_W-1:0]  start_last,
    input  logic [MASK_W-1:0] start_mask,
    output logic              busy,
    output logic              we,
    output logic [PAW-1:0]    widx,
    output logic [PAW-1:0]    ridx,
    output eng_state_e        state_o
);
    eng_state_e        state, nxt;
    logic [LEN_W-1:0]  cnt, last_r;
    logic [DST_W-1:0]  dst_r;
    logic [SRC_W-1:0]  src_r;
    logic [MASK_W-1:0] mask_r;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:                      nxt = start ? start_op : ST_IDLE;
            ST_STIPPLE, ST_FILL, ST_COPY: nxt = (cnt == last_r) ? ST_IDLE : state;
            default:                      nxt = ST_IDLE;
        endcase
    end

    // run registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            last_r <= '0;
            dst_r  <= '0;
            src_r  <= '0;
            mask_r <= '0;
        end else if (state == ST_IDLE && start) begin
            cnt    <= '0;
            last_r <= (start_op == ST_STIPPLE) ? LEN_W'(MASK_W - 1) : start_last;
            dst_r  <= start_dst;
            src_r  <= start_src;
            mask_r <= start_mask;
        end else if (state != ST_IDLE) begin
            cnt    <= cnt + 1'b1;
            mask_r <= mask_r << 1;
        end
    end

    // outputs
    always_comb begin
        busy    = (state != ST_IDLE);
        we      = busy && (state != ST_STIPPLE || mask_r[MASK_W-1]);
        widx    = PAW'(dst_r + DST_W'(cnt));
        ridx    = PAW'(src_r + SRC_W'(cnt));
        state_o = state;
    end
endmodule

// File: rtl/stipple_blit_engine.sv
module stipple_blit_engine
    import sbe_pkg::*;
#(
    parameter int NPIX     = 512,
    parameter bit HAS_DEEP = 1'b1,
    localparam int PAW     = $clog2(NPIX)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_valid,
    output logic           wr_ready,
    input  logic [23:2]    wr_addr,
    input  logic [31:0]    wr_data,
    output logic [31:0]    rd_data,
    output logic           busy,
    input  logic [PAW-1:0] view_idx,
    output logic [7:0]     view_pix8,
    output logic [23:0]    view_pix24
);
    logic       accept, do_latch, do_exec;
    logic [23:0] colour_q;
    eng_state_e start_op, seq_state;
    logic       mem_we;
    logic [PAW-1:0] wr_idx, rd_idx;
    logic [7:0] src8, wdat8;

    assign accept   = wr_valid && wr_ready;
    assign do_latch = accept && !wr_addr[2];
    assign do_exec  = accept && wr_addr[2];
    assign wr_ready = !busy;
    assign rd_data  = '0;

    always_comb begin
        if (!wr_addr[23])                       start_op = ST_STIPPLE;
        else if (wr_data[SRC_W-1:0] == FILL_CODE) start_op = ST_FILL;
        else                                    start_op = ST_COPY;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)        colour_q <= '0;
        else if (do_latch) colour_q <= wr_data[23:0];
    end

    sbe_seq #(.NPIX(NPIX)) seq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (do_exec),
        .start_op   (start_op),
        .start_dst  (wr_addr[22:3]),
        .start_src  (wr_data[SRC_W-1:0]),
        .start_last (wr_data[28:24]),
        .start_mask (wr_data),
        .busy       (busy),
        .we         (mem_we),
        .widx       (wr_idx),
        .ridx       (rd_idx),
        .state_o    (seq_state)
    );

    assign wdat8 = (seq_state == ST_COPY) ? src8 : colour_q[7:0];

    sbe_plane #(.W(8), .NPIX(NPIX)) plane8_i (
        .clk(clk), .rst_n(rst_n), .we(mem_we), .waddr(wr_idx), .wdata(wdat8),
        .raddr(rd_idx), .rdata(src8), .vaddr(view_idx), .vdata(view_pix8)
    );

    generate
        if (HAS_DEEP) begin : g_deep
            logic [23:0] src24, wdat24;
            assign wdat24 = (seq_state == ST_COPY) ? src24 : colour_q;
            sbe_plane #(.W(24), .NPIX(NPIX)) plane24_i (
                .clk(clk), .rst_n(rst_n), .we(mem_we), .waddr(wr_idx), .wdata(wdat24),
                .raddr(rd_idx), .rdata(src24), .vaddr(view_idx), .vdata(view_pix24)
            );
        end else begin : g_flat
            assign view_pix24 = '0;
        end
    endgenerate
endmodule

// File: rtl/sbe_checker.sv
module sbe_checker
    import sbe_pkg::*;
#(
    parameter int PAW = 9
) (
    input logic           clk,
    input logic           rst_n,
    input logic           acc_exec,
    input logic           acc_latch,
    input logic           busy,
    input logic           wr_ready,
    input logic           mem_we,
    input eng_state_e     seq_state,
    input logic [PAW-1:0] wr_idx
);
    logic [5:0] run_q;

    always_ff @(posedge clk) begin
        if (!rst_n)    run_q <= '0;
        else if (busy) run_q <= run_q + 1'b1;
        else           run_q <= '0;
    end

    p_exec_starts_r3: assert property (@(posedge clk) disable iff (!rst_n)
        acc_exec |=> busy);

    p_latch_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        acc_latch |=> !busy);

    p_run_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (run_q < 6'd32));

    p_fill_writes_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == ST_FILL) |-> mem_we);

    p_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !wr_ready);

    p_ascend_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> (wr_idx == PAW'($past(wr_idx) + 1'b1)));
endmodule

bind stipple_blit_engine sbe_checker #(.PAW(PAW)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_exec  (do_exec),
    .acc_latch (do_latch),
    .busy      (busy),
    .wr_ready  (wr_ready),
    .mem_we    (mem_we),
    .seq_state (seq_state),
    .wr_idx    (wr_idx)
);

// File: tb/stipple_blit_engine_tb_top.sv
module stipple_blit_engine_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NPIX = 512;
    localparam int PAW  = $clog2(NPIX);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_valid = 1'b0;
    logic wr_ready;
    logic [23:2] wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic busy;
    logic [PAW-1:0] view_idx = '0;
    logic [7:0]  view_pix8;
    logic [23:0] view_pix24;

    int checks = 0;
    int errors = 0;
    int m8  [NPIX];
    int m24 [NPIX];
    int colour_m = 0;
    int busy_left = 0;
    int pend_len = 0;
    bit clk_check_on = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    stipple_blit_engine #(.NPIX(NPIX), .HAS_DEEP(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_data(rd_data), .busy(busy),
        .view_idx(view_idx), .view_pix8(view_pix8), .view_pix24(view_pix24)
    );

    function automatic logic [23:2] mk_addr(bit blit, int dst, bit exec);
        logic [19:0] d;
        d = dst[19:0];
        return {blit, d, exec};
    endfunction

    // busy model, advanced on every clock
    always @(posedge clk) begin
        if (!rst_n) busy_left <= 0;
        else if (wr_valid && wr_ready && wr_addr[2]) busy_left <= pend_len;
        else if (busy_left > 0) busy_left <= busy_left - 1;
    end

    // per-clock comparison of busy / ready / read data (R4 R5 R9 R10)
    always @(negedge clk) begin
        if (clk_check_on) begin
            checks++;
            if (busy !== (busy_left != 0) || wr_ready !== (busy_left == 0)) begin
                errors++;
                $display("FAIL R10 busy/ready: busy=%0b ready=%0b expected busy=%0b",
                         busy, wr_ready, busy_left != 0);
            end
            if (rd_data !== 32'd0) begin
                errors++;
                $display("FAIL R9 rd_data=%h expected 0", rd_data);
            end
        end
    end

    task automatic model_exec(logic [23:2] a, logic [31:0] d);
        int dst, src, len;
        dst = int'(a[22:3]) % NPIX;
        if (!a[23]) begin
            for (int i = 0; i < 32; i++)
                if (d[31-i]) begin
                    m8[(dst+i)%NPIX]  = colour_m & 8'hFF;
                    m24[(dst+i)%NPIX] = colour_m & 24'hFFFFFF;
                end
        end else begin
            len = int'(d[28:24]) + 1;
            if (d[23:0] == 24'hFFFFFF) begin
                for (int i = 0; i < len; i++) begin
                    m8[(dst+i)%NPIX]  = colour_m & 8'hFF;
                    m24[(dst+i)%NPIX] = colour_m & 24'hFFFFFF;
                end
            end else begin
                src = int'(d[23:0]) % NPIX;
                for (int i = 0; i < len; i++) begin
                    m8[(dst+i)%NPIX]  = m8[(src+i)%NPIX];
                    m24[(dst+i)%NPIX] = m24[(src+i)%NPIX];
                end
            end
        end
    endtask

    task automatic bus_write(logic [23:2] a, logic [31:0] d);
        @(negedge clk);
        wr_addr  = a;
        wr_data  = d;
        pend_len = a[23] ? int'(d[28:24]) + 1 : 32;
        wr_valid = 1'b1;
        while (!wr_ready) @(negedge clk);
        @(posedge clk);
        if (a[2]) model_exec(a, d);
        else      colour_m = int'(d);
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
    endtask

    task automatic scan(string tag);
        int bad;
        bad = 0;
        checks++;
        for (int i = 0; i < NPIX; i++) begin
            view_idx = PAW'(i);
            #1;
            if (bad == 0 && (int'(view_pix8) != m8[i] || int'(view_pix24) != m24[i])) begin
                bad = 1;
                errors++;
                $display("FAIL %s pixel %0d: got %h/%h expected %h/%h",
                         tag, i, view_pix8, view_pix24, m8[i][7:0], m24[i][23:0]);
            end
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < NPIX; i++) begin m8[i] = 0; m24[i] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        clk_check_on = 1'b1;
        // R2 reset state
        checks++;
        if (wr_ready !== 1'b1 || busy !== 1'b0) begin
            errors++;
            $display("FAIL R2 ready=%0b busy=%0b expected 1/0", wr_ready, busy);
        end
        scan("R2 reset contents");

        // R1 colour latch changes nothing
        bus_write(mk_addr(0, 0, 0), 32'h00A1B2C3);
        wait_idle();
        scan("R1 latch only");

        // R4 stipple, edge bits of mask
        bus_write(mk_addr(0, 10, 1), 32'h80000001);
        wait_idle();
        scan("R4 stipple edges");

        // R4 R8 stipple with new colour, mixed mask
        bus_write(mk_addr(0, 0, 0), 32'hFF123455);
        bus_write(mk_addr(0, 100, 1), 32'hF0F00F0F);
        wait_idle();
        scan("R4 R8 stipple pattern");

        // R6 fill of 16 pixels
        bus_write(mk_addr(0, 0, 0), 32'h00ABCD7E);
        bus_write(mk_addr(1, 200, 1), {3'b000, 5'd15, 24'hFFFFFF});
        wait_idle();
        scan("R6 fill");

        // R7 R8 plain copy from mixed stipple region
        bus_write(mk_addr(1, 300, 1), {3'b000, 5'd15, 24'd96});
        wait_idle();
        scan("R7 copy");

        // R7 overlapping forward copy propagates source pixel
        bus_write(mk_addr(1, 101, 1), {3'b000, 5'd7, 24'd100});
        wait_idle();
        scan("R7 overlap copy");

        // R5 length extremes: 32 and 1; source near fill code is a copy
        bus_write(mk_addr(1, 400, 1), {3'b000, 5'd31, 24'd96});
        wait_idle();
        bus_write(mk_addr(1, 450, 1), {3'b000, 5'd0, 24'hFFFFFE});
        wait_idle();
        scan("R5 lengths");

        // R11 wrap of destination run and of high destination bits
        bus_write(mk_addr(0, 0, 0), 32'h00112233);
        bus_write(mk_addr(0, 500, 1), 32'hFFFFFFFF);
        wait_idle();
        bus_write(mk_addr(1, NPIX + 40, 1), {3'b000, 5'd3, 24'hFFFFFF});
        wait_idle();
        bus_write(mk_addr(1, 60, 1), {3'b000, 5'd9, 24'd508});
        wait_idle();
        scan("R11 wrap");

        // R10 back-to-back: colour write held until fill ends
        bus_write(mk_addr(0, 0, 0), 32'h00CAFE01);
        bus_write(mk_addr(1, 250, 1), {3'b000, 5'd20, 24'hFFFFFF});
        bus_write(mk_addr(0, 0, 0), 32'h00BEEF02);
        bus_write(mk_addr(0, 280, 1), 32'hAAAA5555);
        bus_write(mk_addr(1, 320, 1), {3'b000, 5'd4, 24'd250});
        wait_idle();
        scan("R10 stalled sequence");

        // R3 engine select by address bit 23 with same data
        bus_write(mk_addr(0, 350, 1), {3'b000, 5'd2, 24'hFFFFFF});
        wait_idle();
        scan("R3 select");

        // R9 read data stays zero
        checks++;
        if (rd_data !== 32'd0) begin
            errors++;
            $display("FAIL R9 rd_data=%h expected 0", rd_data);
        end

        clk_check_on = 1'b0;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule